// File: doc/BRIEF.md
# Source power-path fault supervisor

This block decides, cycle by cycle, whether the external gate driver that connects a USB Type-C source's supply to the bus may be switched on. It watches a sink-attached flag, an active-low gate-disable input, a supply-undervoltage flag, a bus-voltage-good flag and an overcurrent flag. All of them arrive as clean, synchronous digital levels. From a one-cycle millisecond tick it times two windows. The attach window starts when the block begins waiting to switch on. The bus-rise window starts when the gate has been switched on.

The gate-disable and overcurrent inputs each pass through a deglitch filter before they are acted on. A qualified gate-disable overrides every other reason to conduct. If gate-disable is still held low when the attach window ends, the block pulses a hard-reset request. It then stays off until the sink detaches and attaches again. An undervoltage that lasts the whole attach window, a bus that does not come up within the bus-rise window, and a qualified overcurrent while conducting each latch one fault. A latched fault holds the gate off until a clear input is pulsed. There is no data stream: every pin is a plain control or status level, so no valid/ready handshake or back-pressure applies.

Top module: `pwr_path_supervisor`

## Requirements
- R1: The gate-disable filter acts on a new level of `gate_dis_n` only after it has been sampled GD_DGL clock edges in a row. The overcurrent filter does the same for `overcurrent` over OC_DGL edges. A return to the old level restarts the count, so a shorter bounce has no effect on `gate_en`.
- R2: When the filtered gate-disable level is low, `gate_en` is 0 from the next cycle on, whatever the other inputs are. If the gate was on, the block goes back to waiting and the attach window restarts from zero.
- R3: If filtered gate-disable is still low when ATTACH_MS ticks have been counted while waiting, `hard_reset_req` is 1 for exactly one cycle. After that, `gate_en` stays 0 and no window runs until `sink_attached` has gone low and then high again.
- R4: If `supply_uv` is still 1 when ATTACH_MS ticks have been counted while waiting, and gate-disable is high, `fault_uv` latches to 1. `gate_en` is never 1 during that attach.
- R5: While waiting, if gate-disable is filtered high, `supply_uv` is 0 and the filtered overcurrent is 0, `gate_en` becomes 1 on the next clock edge.
- R6: If `bus_good` is not sampled high before BUS_MS ticks have been counted with the gate on, `fault_fast_shdn` latches to 1 and `gate_en` drops to 0. Once `bus_good` has been seen high, the bus-rise window no longer applies.
- R7: A filtered overcurrent while `gate_en` is 1 latches `fault_oc` and drops `gate_en` on the next cycle.
- R8: After reset all outputs are 0. A low `sink_attached` outside the fault state returns the block to idle, drops `gate_en` the next cycle and clears both windows. A latched fault is not affected by detach.
- R9: A `fault_clear` pulse in the fault state clears all three fault flags and returns the block to idle. At most one fault flag is 1 at any time, and `gate_en` is 0 while any flag is 1.
- R10: When the attach window ends with both gate-disable low and `supply_uv` 1, only the hard-reset request is issued and `fault_uv` stays 0. When the gate-disable and overcurrent filters qualify on the same edge while conducting, the block returns to waiting and `fault_oc` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| sink_attached | input | 1 | 1 while a sink is attached |
| gate_dis_n | input | 1 | Gate-disable request, active low |
| supply_uv | input | 1 | 1 when the supply is below its falling undervoltage threshold |
| bus_good | input | 1 | 1 when the bus voltage is above its rising threshold |
| overcurrent | input | 1 | Raw overcurrent comparator level |
| fault_clear | input | 1 | Clears a latched fault |
| gate_en | output | 1 | Gate driver enable |
| hard_reset_req | output | 1 | One-cycle hard-reset request |
| fault_uv | output | 1 | Latched supply-undervoltage fault |
| fault_fast_shdn | output | 1 | Latched bus-rise timeout fault |
| fault_oc | output | 1 | Latched overcurrent fault |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the end of the attach window, where a held-low gate-disable and a held undervoltage both qualify. The second is the two deglitch filters, which can both qualify on one edge while the gate is on. The bench provokes the second pair by lowering `gate_dis_n` one cycle before raising `overcurrent`, since the overcurrent filter is one cycle shorter. It provokes the first pair by attaching with both conditions already present. In both cases it judges that gate-disable wins: there is one hard-reset pulse or a plain return to waiting, and no fault flag.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ON,
    ST_RUN,
    ST_HOLD,
    ST_FAULT
  } pps_state_e;

  typedef enum logic [1:0] {
    FLT_NONE,
    FLT_UV,
    FLT_FS,
    FLT_OC
  } pps_fault_e;
endpackage

// File: rtl/pps_glitch_filter.sv
module pps_glitch_filter #(
  parameter int unsigned CYC     = 4,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned CW = (CYC < 2) ? 1 : $clog2(CYC);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= RST_VAL;
      run_cnt <= '0;
    end else if (d == q) begin
      run_cnt <= '0;
    end else if (run_cnt == CW'(CYC - 1)) begin
      q       <= d;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + CW'(1);
    end
  end

  // R1: the filtered level only moves toward the level just sampled
  p_flip_follows_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> (q == $past(d)));
endmodule

// File: rtl/pps_ms_window.sv
module pps_ms_window #(
  parameter int unsigned LIMIT = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] ms_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_cnt <= '0;
    end else if (!run) begin
      ms_cnt <= '0;
    end else if (tick && (ms_cnt != W'(LIMIT))) begin
      ms_cnt <= ms_cnt + W'(1);
    end
  end

  assign expired = (ms_cnt == W'(LIMIT));

  // R3: a window can only end on a millisecond tick while it is running
  p_expiry_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> ($past(tick) && $past(run)));
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic attached,
  input  logic gd_ok,
  input  logic uv,
  input  logic bus_ok,
  input  logic oc,
  input  logic clr,
  input  logic attach_exp,
  input  logic bus_exp,
  output logic attach_run,
  output logic bus_run,
  output logic gate_en,
  output logic hr_req,
  output logic flt_uv,
  output logic flt_fs,
  output logic flt_oc
);
  pps_state_e st_q, st_d;
  pps_fault_e flt_q, flt_d;
  logic       hr_d;

  always_comb begin
    st_d  = st_q;
    flt_d = flt_q;
    hr_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (attached) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!attached) st_d = ST_IDLE;
        else if (gd_ok && !uv && !oc) st_d = ST_ON;
        else if (attach_exp && !gd_ok) begin
          st_d = ST_HOLD;
          hr_d = 1'b1;
        end else if (attach_exp && uv) begin
          st_d  = ST_FAULT;
          flt_d = FLT_UV;
        end
      end
      ST_ON: begin
        if (!attached) st_d = ST_IDLE;
        else if (!gd_ok) st_d = ST_WAIT;
        else if (oc) begin
          st_d  = ST_FAULT;
          flt_d = FLT_OC;
        end else if (bus_ok) st_d = ST_RUN;
        else if (bus_exp) begin
          st_d  = ST_FAULT;
          flt_d = FLT_FS;
        end
      end
      ST_RUN: begin
        if (!attached) st_d = ST_IDLE;
        else if (!gd_ok) st_d = ST_WAIT;
        else if (oc) begin
          st_d  = ST_FAULT;
          flt_d = FLT_OC;
        end
      end
      ST_HOLD: if (!attached) st_d = ST_IDLE;
      ST_FAULT: if (clr) begin
        st_d  = ST_IDLE;
        flt_d = FLT_NONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      flt_q  <= FLT_NONE;
      hr_req <= 1'b0;
    end else begin
      st_q   <= st_d;
      flt_q  <= flt_d;
      hr_req <= hr_d;
    end
  end

  assign attach_run = (st_q == ST_WAIT);
  assign bus_run    = (st_q == ST_ON);
  assign gate_en    = (st_q == ST_ON) || (st_q == ST_RUN);
  assign flt_uv     = (flt_q == FLT_UV);
  assign flt_fs     = (flt_q == FLT_FS);
  assign flt_oc     = (flt_q == FLT_OC);

  // R2: a qualified gate-disable removes the gate on the next cycle
  p_gd_override_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gd_ok |=> !gate_en);
  // R3: the hard-reset request lasts one cycle
  p_hr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hr_req |=> !hr_req);
  // R7: overcurrent while conducting turns the gate off
  p_oc_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oc && gate_en) |=> !gate_en);
  // R8: detach outside a fault leaves the gate off
  p_detach_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !attached |=> !gate_en);
  // R9: fault flags exclusive and gate off under a fault
  p_flags_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flt_uv, flt_fs, flt_oc}));
  p_no_gate_in_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_uv || flt_fs || flt_oc) |-> !gate_en);
endmodule

// File: rtl/pwr_path_supervisor.sv
module pwr_path_supervisor #(
  parameter int unsigned GD_DGL    = 4,
  parameter int unsigned OC_DGL    = 3,
  parameter int unsigned ATTACH_MS = 600,
  parameter int unsigned BUS_MS    = 190
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic sink_attached,
  input  logic gate_dis_n,
  input  logic supply_uv,
  input  logic bus_good,
  input  logic overcurrent,
  input  logic fault_clear,
  output logic gate_en,
  output logic hard_reset_req,
  output logic fault_uv,
  output logic fault_fast_shdn,
  output logic fault_oc
);
  logic gd_ok, oc_f;
  logic attach_run, bus_run, attach_exp, bus_exp;

  pps_glitch_filter #(.CYC(GD_DGL), .RST_VAL(1'b1)) u_gd_filt (
    .clk(clk), .rst_n(rst_n), .d(gate_dis_n), .q(gd_ok));

  pps_glitch_filter #(.CYC(OC_DGL), .RST_VAL(1'b0)) u_oc_filt (
    .clk(clk), .rst_n(rst_n), .d(overcurrent), .q(oc_f));

  pps_ms_window #(.LIMIT(ATTACH_MS)) u_attach_win (
    .clk(clk), .rst_n(rst_n), .run(attach_run), .tick(ms_tick), .expired(attach_exp));

  pps_ms_window #(.LIMIT(BUS_MS)) u_bus_win (
    .clk(clk), .rst_n(rst_n), .run(bus_run), .tick(ms_tick), .expired(bus_exp));

  pps_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .attached(sink_attached), .gd_ok(gd_ok), .uv(supply_uv), .bus_ok(bus_good),
    .oc(oc_f), .clr(fault_clear), .attach_exp(attach_exp), .bus_exp(bus_exp),
    .attach_run(attach_run), .bus_run(bus_run), .gate_en(gate_en),
    .hr_req(hard_reset_req), .flt_uv(fault_uv), .flt_fs(fault_fast_shdn), .flt_oc(fault_oc));
endmodule

// File: tb/pwr_path_supervisor_tb.sv
module pwr_path_supervisor_tb;
  localparam int GD = 4, OC = 3, ATT = 6, BUS = 4, TICK_DIV = 5;
  localparam int M_IDLE = 0, M_WAIT = 1, M_ON = 2, M_RUN = 3, M_HOLD = 4, M_FLT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ms_tick = 1'b0, sink_attached = 1'b0, gate_dis_n = 1'b1, supply_uv = 1'b0;
  logic bus_good = 1'b0, overcurrent = 1'b0, fault_clear = 1'b0;
  logic gate_en, hard_reset_req, fault_uv, fault_fast_shdn, fault_oc;

  int total = 0, bad = 0, cyc = 0, hr_cnt = 0, on_cnt = 0;
  bit done = 1'b0;
  string cur_req = "R8";

  always #2 clk = ~clk;

  pwr_path_supervisor #(.GD_DGL(GD), .OC_DGL(OC), .ATTACH_MS(ATT), .BUS_MS(BUS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sink_attached(sink_attached),
    .gate_dis_n(gate_dis_n), .supply_uv(supply_uv), .bus_good(bus_good),
    .overcurrent(overcurrent), .fault_clear(fault_clear), .gate_en(gate_en),
    .hard_reset_req(hard_reset_req), .fault_uv(fault_uv),
    .fault_fast_shdn(fault_fast_shdn), .fault_oc(fault_oc));

  // behavioural reference model
  int m_st = M_IDLE, m_wc = 0, m_bc = 0;
  bit m_gd = 1'b1, m_oc = 1'b0, m_hr = 1'b0, m_fu = 1'b0, m_ff = 1'b0, m_fo = 1'b0;
  bit gq[$], oq[$];

  always @(posedge clk or negedge rst_n) begin : mdl
    int ns;
    bit nhr, flip;
    if (!rst_n) begin
      m_st = M_IDLE; m_wc = 0; m_bc = 0; m_gd = 1'b1; m_oc = 1'b0; m_hr = 1'b0;
      m_fu = 1'b0; m_ff = 1'b0; m_fo = 1'b0; gq.delete(); oq.delete();
    end else begin
      ns = m_st; nhr = 1'b0;
      case (m_st)
        M_IDLE: if (sink_attached) ns = M_WAIT;
        M_WAIT: if (!sink_attached) ns = M_IDLE;
          else if (m_gd && !supply_uv && !m_oc) ns = M_ON;
          else if (m_wc >= ATT && !m_gd) begin ns = M_HOLD; nhr = 1'b1; end
          else if (m_wc >= ATT && supply_uv) begin ns = M_FLT; m_fu = 1'b1; end
        M_ON: if (!sink_attached) ns = M_IDLE;
          else if (!m_gd) ns = M_WAIT;
          else if (m_oc) begin ns = M_FLT; m_fo = 1'b1; end
          else if (bus_good) ns = M_RUN;
          else if (m_bc >= BUS) begin ns = M_FLT; m_ff = 1'b1; end
        M_RUN: if (!sink_attached) ns = M_IDLE;
          else if (!m_gd) ns = M_WAIT;
          else if (m_oc) begin ns = M_FLT; m_fo = 1'b1; end
        M_HOLD: if (!sink_attached) ns = M_IDLE;
        default: if (fault_clear) begin ns = M_IDLE; m_fu = 0; m_ff = 0; m_fo = 0; end
      endcase
      if (m_st == M_WAIT) begin if (ms_tick && m_wc < ATT) m_wc++; end else m_wc = 0;
      if (m_st == M_ON) begin if (ms_tick && m_bc < BUS) m_bc++; end else m_bc = 0;
      gq.push_back(gate_dis_n);
      if (gq.size() > GD) void'(gq.pop_front());
      flip = (gq.size() == GD);
      foreach (gq[i]) if (gq[i] == m_gd) flip = 1'b0;
      if (flip) m_gd = ~m_gd;
      oq.push_back(overcurrent);
      if (oq.size() > OC) void'(oq.pop_front());
      flip = (oq.size() == OC);
      foreach (oq[i]) if (oq[i] == m_oc) flip = 1'b0;
      if (flip) m_oc = ~m_oc;
      m_st = ns; m_hr = nhr;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, tick generation and event counters
  always @(negedge clk) begin
    cyc++;
    ms_tick = (cyc % TICK_DIV == 0);
    if (rst_n && !done) begin
      chk(cur_req, "gate_en vs model", gate_en, m_st == M_ON || m_st == M_RUN);
      chk(cur_req, "hard_reset_req vs model", hard_reset_req, m_hr);
      chk(cur_req, "fault flags vs model", {fault_uv, fault_fast_shdn, fault_oc}, {m_fu, m_ff, m_fo});
      if (hard_reset_req) hr_cnt++;
      if (gate_en) on_cnt++;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_fault();
    fault_clear = 1'b1; wait_cyc(1); fault_clear = 1'b0; wait_cyc(2);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    wait_cyc(3);
    cur_req = "R8";
    chk("R8", "reset gate_en", gate_en, 0);
    chk("R8", "reset flags", {hard_reset_req, fault_uv, fault_fast_shdn, fault_oc}, 0);
    rst_n = 1'b1;
    wait_cyc(2);

    // R5: enable when all conditions are good, then bus comes up
    cur_req = "R5";
    sink_attached = 1'b1;
    wait_cyc(5);
    chk("R5", "gate on after attach", gate_en, 1);
    bus_good = 1'b1;
    cur_req = "R6";
    wait_cyc(60);
    chk("R6", "no fault once bus good", fault_fast_shdn, 0);

    // R1: short bounces on both filtered inputs
    cur_req = "R1";
    gate_dis_n = 1'b0; wait_cyc(GD - 1); gate_dis_n = 1'b1;
    overcurrent = 1'b1; wait_cyc(OC - 1); overcurrent = 1'b0;
    wait_cyc(8);
    chk("R1", "gate still on after bounces", gate_en, 1);
    chk("R1", "no oc fault after bounce", fault_oc, 0);

    // R2 / R3: held gate-disable, then hard reset and fresh attach
    cur_req = "R2";
    hr_cnt = 0;
    gate_dis_n = 1'b0;
    wait_cyc(GD + 2);
    chk("R2", "gate off after gate-disable", gate_en, 0);
    cur_req = "R3";
    wait_cyc(60);
    chk("R3", "one hard-reset pulse", hr_cnt, 1);
    chk("R3", "no fault flag on hard reset", {fault_uv, fault_fast_shdn, fault_oc}, 0);
    gate_dis_n = 1'b1;
    wait_cyc(40);
    chk("R3", "gate stays off without fresh attach", gate_en, 0);
    sink_attached = 1'b0; wait_cyc(3); sink_attached = 1'b1;
    wait_cyc(GD + 8);
    chk("R3", "gate on after fresh attach", gate_en, 1);

    // R8: detach while on, reattach restarts bus window
    cur_req = "R8";
    sink_attached = 1'b0; bus_good = 1'b0;
    wait_cyc(2);
    chk("R8", "gate off after detach", gate_en, 0);
    sink_attached = 1'b1;
    wait_cyc(10);
    chk("R8", "gate on after reattach", gate_en, 1);

    // R6: bus never rises
    cur_req = "R6";
    wait_cyc(40);
    chk("R6", "fast shutdown latched", fault_fast_shdn, 1);
    chk("R6", "gate off on fast shutdown", gate_en, 0);
    cur_req = "R8";
    sink_attached = 1'b0;
    wait_cyc(5);
    chk("R8", "fault survives detach", fault_fast_shdn, 1);
    cur_req = "R9";
    clear_fault();
    chk("R9", "clear drops flags", {fault_uv, fault_fast_shdn, fault_oc}, 0);

    // R4: undervoltage through the whole attach window
    cur_req = "R4";
    supply_uv = 1'b1; on_cnt = 0;
    sink_attached = 1'b1;
    wait_cyc(60);
    chk("R4", "uv fault latched", fault_uv, 1);
    chk("R4", "gate never on", on_cnt, 0);
    supply_uv = 1'b0;
    wait_cyc(5);
    chk("R4", "uv fault held after uv clears", fault_uv, 1);
    sink_attached = 1'b0;
    clear_fault();

    // R7: overcurrent while conducting
    cur_req = "R7";
    bus_good = 1'b1; sink_attached = 1'b1;
    wait_cyc(10);
    chk("R7", "gate on before overcurrent", gate_en, 1);
    overcurrent = 1'b1;
    wait_cyc(OC + 2);
    chk("R7", "oc fault latched", fault_oc, 1);
    chk("R7", "gate off on oc", gate_en, 0);
    overcurrent = 1'b0; sink_attached = 1'b0;
    wait_cyc(5);
    cur_req = "R9";
    clear_fault();
    chk("R9", "oc flag cleared", fault_oc, 0);

    // R10: both window conditions at once
    cur_req = "R10";
    hr_cnt = 0;
    gate_dis_n = 1'b0; supply_uv = 1'b1;
    wait_cyc(GD + 2);
    sink_attached = 1'b1;
    wait_cyc(60);
    chk("R10", "hard reset wins over uv", hr_cnt, 1);
    chk("R10", "no uv fault", fault_uv, 0);
    sink_attached = 1'b0; gate_dis_n = 1'b1; supply_uv = 1'b0;
    wait_cyc(GD + 3);

    // R10: both filters qualify on one edge while conducting
    sink_attached = 1'b1;
    wait_cyc(10);
    chk("R10", "gate on before collision", gate_en, 1);
    gate_dis_n = 1'b0;
    wait_cyc(1);
    overcurrent = 1'b1;
    wait_cyc(GD + 4);
    chk("R10", "no oc fault on collision", fault_oc, 0);
    chk("R10", "gate off on collision", gate_en, 0);
    sink_attached = 1'b0; overcurrent = 1'b0; gate_dis_n = 1'b1;
    wait_cyc(10);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule